// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for a synchronous memory array. A base address is captured whenever either of two independent load strobes is high at a rising clock edge. After that, the block can step through a four-beat burst on its own. On each step only the two lowest address bits change, and the upper bits stay as they were when the address was loaded. A step happens only on a clock edge where the advance input is high. If no strobe and no advance is present, the address holds.

The order input chooses how the low bits move through the aligned group of four words. In linear order they count upward and wrap. In interleaved order the start bits are XOR-ed with the beat number. Tying the order input low gives interleaved order, which is the default strapping. Bursting is optional, because a fresh external address can be loaded on every edge without any lost cycle. The block has a registered output: every change shows on `mem_addr` one edge after the controls that caused it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `mem_addr` is 0 and `beat` is 0.
- R2: If `load_a` or `load_b` (or both) is high at a rising edge, then after that edge `mem_addr` equals the `ext_addr` sampled at that edge and `beat` is 0.
- R3: With both strobes low and `advance` high at an edge, `beat` becomes (previous `beat` + 1) mod 4, so it wraps from 3 to 0.
- R4: Without a strobe, address bits 14 down to 2 never change.
- R5: With `order_lin` = 1 (linear), after each advance the low two address bits equal (start + `beat`) mod 4. Start is the low two bits of the loaded address.
- R6: With `order_lin` = 0 (interleaved, the default strap), after each advance the low two address bits equal start XOR `beat`. From a start of 2 this gives 2, 3, 0, 1.
- R7: With both strobes and `advance` low, `mem_addr` and `beat` keep their values, whatever `ext_addr` does.
- R8: A strobe that coincides with `advance` performs a load, and no step is made.
- R9: Loads on consecutive edges each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; all other inputs except `rst_n` are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_a | input | 1 | First address load strobe |
| load_b | input | 1 | Second address load strobe |
| advance | input | 1 | Step the burst by one beat |
| order_lin | input | 1 | 1 = linear wrap order, 0 = interleaved XOR order |
| ext_addr | input | 15 | Externally supplied word address |
| mem_addr | output | 15 | Registered word address to the array |
| beat | output | 2 | Beats taken since the last load, mod 4 |

## Verification
The block has a single register stage, so every result is due exactly one rising edge after the inputs that cause it. This holds for loads, steps and holds alike. The bench changes inputs on the falling edge. It then waits for the next rising edge and samples shortly after that edge, before the next falling edge changes anything, so each check sees the outcome of exactly one command. Reset is asynchronous, and its value is checked while `rst_n` is still low, without waiting for an edge.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } burst_op_e;

endpackage

// File: rtl/burst_cmd_arb.sv
module burst_cmd_arb
    import burst_addr_pkg::*;
(
    input  logic      load_a,
    input  logic      load_b,
    input  logic      advance,
    output burst_op_e op
);

    // A strobe always wins over advance.
    always_comb begin
        if (load_a || load_b) begin
            op = OP_LOAD;
        end else if (advance) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/burst_order_step.sv
module burst_order_step #(
    parameter int BW = 2
) (
    input  logic [BW-1:0] start,
    input  logic [BW-1:0] beat_nx,
    input  logic          linear,
    output logic [BW-1:0] low
);

    logic [BW-1:0] lin_low;
    logic [BW-1:0] ilv_low;

    // Linear order: modular add, which wraps inside the aligned group.
    assign lin_low = start + beat_nx;

    // Interleaved order: bitwise XOR, built one bit at a time.
    for (genvar i = 0; i < BW; i++) begin : g_ilv
        assign ilv_low[i] = start[i] ^ beat_nx[i];
    end

    assign low = linear ? lin_low : ilv_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_a,
    input  logic              load_b,
    input  logic              advance,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BW-1:0]     beat
);

    localparam int UP_W = ADDR_W - BW;

    typedef struct packed {
        logic [UP_W-1:0] upper;
        logic [BW-1:0]   start;
        logic [BW-1:0]   beat;
        logic [BW-1:0]   low;
    } gen_state_t;

    gen_state_t st_d;
    gen_state_t st_q;
    burst_op_e  op;
    logic [BW-1:0] beat_nx;
    logic [BW-1:0] step_low;

    burst_cmd_arb u_arb (
        .load_a  (load_a),
        .load_b  (load_b),
        .advance (advance),
        .op      (op)
    );

    assign beat_nx = st_q.beat + BW'(1);

    burst_order_step #(.BW(BW)) u_step (
        .start   (st_q.start),
        .beat_nx (beat_nx),
        .linear  (order_lin),
        .low     (step_low)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.upper = ext_addr[ADDR_W-1:BW];
                st_d.start = ext_addr[BW-1:0];
                st_d.low   = ext_addr[BW-1:0];
                st_d.beat  = '0;
            end
            OP_STEP: begin
                st_d.beat = beat_nx;
                st_d.low  = step_low;
            end
            default: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr = {st_q.upper, st_q.low};
    assign beat     = st_q.beat;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (mem_addr == '0 && beat == '0)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a || load_b) |=> (mem_addr == $past(ext_addr) && beat == '0)); // R2

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a && !load_b && advance) |=> beat == BW'($past(beat) + BW'(1))); // R3

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a && !load_b) |=> $stable(mem_addr[ADDR_W-1:BW])); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a && !load_b && !advance) |=> ($stable(mem_addr) && $stable(beat))); // R7

endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;

    localparam int AW = 15;
    localparam int NV = 16;
    // Layout: load_a, load_b, advance, order_lin, ext_addr[15], exp_addr[15], exp_beat[2]
    localparam int VW = 4 + AW + AW + 2;

    localparam logic [VW-1:0] VEC [0:NV-1] = '{
        {4'b1000, 15'h1232, 15'h1232, 2'd0},  // R2 load_a, start 2
        {4'b0010, 15'h0000, 15'h1233, 2'd1},  // R6 2^1=3
        {4'b0010, 15'h7FFF, 15'h1230, 2'd2},  // R6 2^2=0
        {4'b0010, 15'h0000, 15'h1231, 2'd3},  // R6 2^3=1
        {4'b0010, 15'h0000, 15'h1232, 2'd0},  // R3 wrap to beat 0
        {4'b0101, 15'h7FFD, 15'h7FFD, 2'd0},  // R2 load_b, start 1
        {4'b0011, 15'h0000, 15'h7FFE, 2'd1},  // R5 1+1
        {4'b0001, 15'h0123, 15'h7FFE, 2'd1},  // R7 hold
        {4'b0011, 15'h0000, 15'h7FFF, 2'd2},  // R5 1+2
        {4'b0011, 15'h0000, 15'h7FFC, 2'd3},  // R5 wraps, R4 upper kept
        {4'b1011, 15'h0403, 15'h0403, 2'd0},  // R8 load beats advance
        {4'b1000, 15'h2AA8, 15'h2AA8, 2'd0},  // R9 back-to-back
        {4'b0100, 15'h5556, 15'h5556, 2'd0},  // R9 back-to-back
        {4'b0010, 15'h0000, 15'h5557, 2'd1},  // R6 2^1
        {4'b1100, 15'h0001, 15'h0001, 2'd0},  // R2 both strobes
        {4'b0011, 15'h0000, 15'h0002, 2'd1}   // R5 1+1
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_a = 1'b0;
    logic          load_b = 1'b0;
    logic          advance = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [1:0]    beat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_a    (load_a),
        .load_b    (load_b),
        .advance   (advance),
        .order_lin (order_lin),
        .ext_addr  (ext_addr),
        .mem_addr  (mem_addr),
        .beat      (beat)
    );

    function automatic string vec_req(int k);
        case (k)
            0, 5, 14:      return "R2";
            4:             return "R3";
            9:             return "R4/R5";
            6, 8, 15:      return "R5";
            1, 2, 3, 13:   return "R6";
            7:             return "R7";
            10:            return "R8";
            default:       return "R9";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step_cycle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        // R1: reset values while reset is held
        #12;
        chk("R1", "addr in reset", int'(mem_addr), 0);
        chk("R1", "beat in reset", int'(beat), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {load_a, load_b, advance, order_lin} = VEC[k][VW-1 -: 4];
            ext_addr = VEC[k][VW-5 -: AW];
            step_cycle();
            chk(vec_req(k), $sformatf("vec %0d addr", k), int'(mem_addr), int'(VEC[k][AW+1 : 2]));
            chk(vec_req(k), $sformatf("vec %0d beat", k), int'(beat), int'(VEC[k][1:0]));
        end

        // R7: idle with ext_addr changing, over several edges
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            {load_a, load_b, advance} = 3'b000;
            ext_addr = AW'(15'h1111 * (k + 3));
            step_cycle();
            chk("R7", "idle addr", int'(mem_addr), 15'h0002);
            chk("R7", "idle beat", int'(beat), 1);
        end

        // R6: full interleaved burst from start 1 -> 1,0,3,2
        @(negedge clk);
        {load_a, load_b, advance, order_lin} = 4'b1000;
        ext_addr = 15'h4C35;
        step_cycle();
        chk("R2", "load 4C35", int'(mem_addr), 15'h4C35);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            {load_a, load_b, advance} = 3'b001;
            step_cycle();
            chk("R6", $sformatf("ilv beat %0d", k), int'(mem_addr), int'({13'h130D, 2'(1 ^ k)}));
        end

        // R1: reset in the middle of a burst
        @(negedge clk);
        {load_a, load_b, advance} = 3'b000;
        rst_n = 1'b0;
        #2;
        chk("R1", "mid-run reset addr", int'(mem_addr), 0);
        chk("R1", "mid-run reset beat", int'(beat), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule